// File: doc/BRIEF.md
# Write-Back Data Cache with Refill Fault Tagging

This block is a small direct-mapped data cache placed between a load/store unit and a word-wide memory bus. It allocates on both loads and stores and writes dirty data back only on eviction. The memory bus answers every beat with an acknowledge and may flag it as an error. A line refilled while any of its beats came back with an error is still installed, but it carries a fault flag. Until it is evicted, such a line answers loads with a load access fault and swallows stores without a trap. A faulted line is never written back, so data stored into it never reaches memory.

Addresses that match a configured uncached window (address AND mask equals base) never touch the cache. Each such access becomes a single bus beat, whatever the access type. Every other address is cached, whatever the privilege level of the requester. The CPU side is a one-request-at-a-time port with a `busy` indication. The cache allows at most one miss in flight.

Top module: `fault_tag_dcache`

## Requirements
- R1: A load from a cached address returns the most recent data stored to it, across evictions. A store updates byte lane i (bits 8i+7..8i) of the word only when bit i of `req_be` is 1.
- R2: A load or store that hits in the cache causes no bus beat. Its response (`rsp_valid` high) appears in the cycle right after the request is accepted.
- R3: If any beat of a line refill returns `bus_err` = 1, a load to that line responds with `rsp_fault` = 1 and `rsp_rdata` = 0.
- R4: A store to a faulted line responds with `rsp_fault` = 0 and causes no bus beat. Its data never reaches memory.
- R5: A miss whose victim is valid, dirty and not faulted first writes the victim back (WORDS write beats) and then refills (WORDS read beats). A miss whose victim is clean, invalid or faulted does only the WORDS read beats.
- R6: An address with (addr & IO_MASK) == IO_BASE causes exactly one bus beat at that address, with the request's byte enables and write data. A load returns `bus_rdata`. `rsp_fault` equals `bus_err` for both loads and stores.
- R7: `busy` is high from the cycle after a miss or IO request is accepted until its response cycle. `bus_req` is low whenever the cache is idle.
- R8: A refill that completes with no error clears the fault flag, so a later load from the new line returns data with `rsp_fault` = 0.
- R9: During and after reset `rsp_valid` and `bus_req` are low and all lines are invalid. The first access to any cached address performs a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present; accepted in a cycle where `busy` is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables, bit i selects byte lane i |
| busy | output | 1 | Cache cannot take a request this cycle |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Load data, 0 for stores and faults |
| rsp_fault | output | 1 | Access fault for this response |
| bus_req | output | 1 | Bus beat requested, held until acknowledged |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 32 | Beat word address |
| bus_wdata | output | 32 | Beat write data |
| bus_be | output | 4 | Beat byte enables |
| bus_ack | input | 1 | Beat complete (one-cycle pulse) |
| bus_rdata | input | 32 | Beat read data |
| bus_err | input | 1 | Beat ended with an error |

## Verification
The hardest state to reach from the ports is a faulted line that sits in a set whose previous occupant was dirty. A later good miss to that set must then evict the faulted line without a writeback. The directed part of the stimulus builds this case first. It dirties a line, evicts it with a conflicting address, replaces that with a line from the error-returning region, stores into it, and then evicts it again, counting bus beats at each step. A random phase then mixes good, erroring and uncached addresses that alias heavily onto the sixteen sets. Every load is checked against a byte-merged reference memory, and the bench confirms that no write ever lands in the error region.

// File: rtl/ftd_pkg.sv
package ftd_pkg;
  localparam int unsigned FTD_WORD_BITS = 32;
  localparam int unsigned FTD_LANES     = FTD_WORD_BITS / 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_RESP,
    ST_UNCACHED
  } ftd_state_e;
endpackage

// File: rtl/ftd_line_state.sv
module ftd_line_state #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic             rd_fault,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic             wr_fault
);
  logic [TAG_W-1:0] tag_q   [SETS];
  logic [SETS-1:0]  valid_q;
  logic [SETS-1:0]  dirty_q;
  logic [SETS-1:0]  fault_q;

  for (genvar g = 0; g < SETS; g++) begin : g_set
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        fault_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g] <= wr_valid;
        dirty_q[g] <= wr_dirty;
        fault_q[g] <= wr_fault;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[g] <= wr_tag;
    end
  end

  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_fault = fault_q[rd_idx];

  // a line installed with its fault flag set never becomes dirty
  AST_FAULTED_NEVER_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_fault |-> !wr_dirty); // R4
endmodule

// File: rtl/ftd_line_data.sv
module ftd_line_data #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WRD_W = $clog2(WORDS),
  localparam int unsigned DEPTH = SETS * WORDS
) (
  input  logic                             clk,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [WRD_W-1:0]                 rd_word,
  output logic [ftd_pkg::FTD_WORD_BITS-1:0] rd_data,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [WRD_W-1:0]                 wr_word,
  input  logic [ftd_pkg::FTD_LANES-1:0]     wr_be,
  input  logic [ftd_pkg::FTD_WORD_BITS-1:0] wr_data
);
  logic [ftd_pkg::FTD_WORD_BITS-1:0] mem_q [DEPTH];
  logic [IDX_W+WRD_W-1:0] wa;
  logic [IDX_W+WRD_W-1:0] ra;

  assign wa = {wr_idx, wr_word};
  assign ra = {rd_idx, rd_word};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < int'(ftd_pkg::FTD_LANES); b++) begin
        if (wr_be[b]) mem_q[wa][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  assign rd_data = mem_q[ra];
endmodule

// File: rtl/fault_tag_dcache.sv
module fault_tag_dcache #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SETS    = 16,
  parameter int unsigned WORDS   = 4,
  parameter logic [31:0] IO_BASE = 32'h1000_0000,
  parameter logic [31:0] IO_MASK = 32'hFFFF_0000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [ftd_pkg::FTD_WORD_BITS-1:0] req_wdata,
  input  logic [ftd_pkg::FTD_LANES-1:0]     req_be,
  output logic                              busy,
  output logic                              rsp_valid,
  output logic [ftd_pkg::FTD_WORD_BITS-1:0] rsp_rdata,
  output logic                              rsp_fault,
  output logic                              bus_req,
  output logic                              bus_we,
  output logic [ADDR_W-1:0]                 bus_addr,
  output logic [ftd_pkg::FTD_WORD_BITS-1:0] bus_wdata,
  output logic [ftd_pkg::FTD_LANES-1:0]     bus_be,
  input  logic                              bus_ack,
  input  logic [ftd_pkg::FTD_WORD_BITS-1:0] bus_rdata,
  input  logic                              bus_err
);
  import ftd_pkg::*;

  localparam int unsigned DW    = FTD_WORD_BITS;
  localparam int unsigned BW    = FTD_LANES;
  localparam int unsigned OFS_W = $clog2(BW);
  localparam int unsigned WRD_W = $clog2(WORDS);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - WRD_W - OFS_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // controller state
  ftd_state_e       st_q, st_d;
  logic             pw_q, pw_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [DW-1:0]    pd_q, pd_d;
  logic [BW-1:0]    pb_q, pb_d;
  logic [WRD_W-1:0] beat_q, beat_d;
  logic             ferr_q, ferr_d;
  logic             rv_q, rv_d;
  logic [DW-1:0]    rd_q, rd_d;
  logic             rf_q, rf_d;

  // address split
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  idx;
  logic [WRD_W-1:0]  wrd;
  logic [TAG_W-1:0]  tag;
  logic              io_hit;

  assign cur_addr = (st_q == ST_IDLE) ? req_addr : pa_q;
  assign idx      = cur_addr[OFS_W+WRD_W +: IDX_W];
  assign wrd      = cur_addr[OFS_W +: WRD_W];
  assign tag      = cur_addr[ADDR_W-1 -: TAG_W];
  assign io_hit   = ((cur_addr & ADDR_W'(IO_MASK)) == ADDR_W'(IO_BASE));

  // storage
  logic [TAG_W-1:0] t_tag;
  logic             t_valid, t_dirty, t_fault;
  logic             tw_en, tw_dirty, tw_fault;
  logic [DW-1:0]    d_rdata;
  logic             dw_en;
  logic [WRD_W-1:0] dw_word;
  logic [BW-1:0]    dw_be;
  logic [DW-1:0]    dw_data;

  ftd_line_state #(.SETS(SETS), .TAG_W(TAG_W)) u_state (
    .clk      (clk),
    .rst_n    (rst_sn),
    .rd_idx   (idx),
    .rd_tag   (t_tag),
    .rd_valid (t_valid),
    .rd_dirty (t_dirty),
    .rd_fault (t_fault),
    .wr_en    (tw_en),
    .wr_idx   (idx),
    .wr_tag   (tag),
    .wr_valid (1'b1),
    .wr_dirty (tw_dirty),
    .wr_fault (tw_fault)
  );

  ftd_line_data #(.SETS(SETS), .WORDS(WORDS)) u_data (
    .clk     (clk),
    .rd_idx  (idx),
    .rd_word ((st_q == ST_EVICT) ? beat_q : wrd),
    .rd_data (d_rdata),
    .wr_en   (dw_en),
    .wr_idx  (idx),
    .wr_word (dw_word),
    .wr_be   (dw_be),
    .wr_data (dw_data)
  );

  logic hit, accept, last_beat, do_op, op_we;
  logic [DW-1:0] op_wdata;
  logic [BW-1:0] op_be;

  assign busy      = (st_q != ST_IDLE) || !rst_sn;
  assign accept    = req_valid && !busy;
  assign hit       = t_valid && (t_tag == tag);
  assign last_beat = (beat_q == WRD_W'(WORDS - 1));
  assign do_op     = (accept && !io_hit && hit) || (st_q == ST_RESP);
  assign op_we     = (st_q == ST_IDLE) ? req_write : pw_q;
  assign op_wdata  = (st_q == ST_IDLE) ? req_wdata : pd_q;
  assign op_be     = (st_q == ST_IDLE) ? req_be    : pb_q;

  // bus side
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_be    = '0;
    unique case (st_q)
      ST_EVICT: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = {t_tag, idx, beat_q, {OFS_W{1'b0}}};
        bus_wdata = d_rdata;
        bus_be    = '1;
      end
      ST_FILL: begin
        bus_req  = 1'b1;
        bus_addr = {tag, idx, beat_q, {OFS_W{1'b0}}};
      end
      ST_UNCACHED: begin
        bus_req   = 1'b1;
        bus_we    = pw_q;
        bus_addr  = pa_q;
        bus_wdata = pd_q;
        bus_be    = pb_q;
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d     = st_q;
    pw_d     = pw_q;
    pa_d     = pa_q;
    pd_d     = pd_q;
    pb_d     = pb_q;
    beat_d   = beat_q;
    ferr_d   = ferr_q;
    rv_d     = 1'b0;
    rd_d     = '0;
    rf_d     = 1'b0;
    tw_en    = 1'b0;
    tw_dirty = 1'b0;
    tw_fault = 1'b0;
    dw_en    = 1'b0;
    dw_word  = wrd;
    dw_be    = op_be;
    dw_data  = op_wdata;

    if (accept && (io_hit || !hit)) begin
      pw_d   = req_write;
      pa_d   = req_addr;
      pd_d   = req_wdata;
      pb_d   = req_be;
      beat_d = '0;
      ferr_d = 1'b0;
      if (io_hit)                            st_d = ST_UNCACHED;
      else if (t_valid && t_dirty && !t_fault) st_d = ST_EVICT;
      else                                   st_d = ST_FILL;
    end

    if (do_op) begin
      rv_d = 1'b1;
      if (op_we) begin
        if (!t_fault) begin
          dw_en    = 1'b1;
          tw_en    = 1'b1;
          tw_dirty = 1'b1;
        end
      end else begin
        rf_d = t_fault;
        rd_d = t_fault ? '0 : d_rdata;
      end
      if (st_q == ST_RESP) st_d = ST_IDLE;
    end

    unique case (st_q)
      ST_EVICT: if (bus_ack) begin
        beat_d = beat_q + WRD_W'(1);
        if (last_beat) st_d = ST_FILL;
      end
      ST_FILL: if (bus_ack) begin
        beat_d  = beat_q + WRD_W'(1);
        ferr_d  = ferr_q | bus_err;
        dw_en   = 1'b1;
        dw_word = beat_q;
        dw_be   = '1;
        dw_data = bus_rdata;
        if (last_beat) begin
          tw_en    = 1'b1;
          tw_fault = ferr_q | bus_err;
          st_d     = ST_RESP;
        end
      end
      ST_UNCACHED: if (bus_ack) begin
        rv_d = 1'b1;
        rf_d = bus_err;
        rd_d = (pw_q || bus_err) ? '0 : bus_rdata;
        st_d = ST_IDLE;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      beat_q <= '0;
      ferr_q <= 1'b0;
      rv_q   <= 1'b0;
      rf_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      st_q   <= st_d;
      beat_q <= beat_d;
      ferr_q <= ferr_d;
      rv_q   <= rv_d;
      rf_q   <= rf_d;
      rd_q   <= rd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pw_q <= pw_d;
      pa_q <= pa_d;
      pd_q <= pd_d;
      pb_q <= pb_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_rdata = rd_q;
  assign rsp_fault = rf_q;

  AST_HIT_ANSWERS_NEXT: assert property (@(posedge clk) disable iff (!rst_sn)
    accept && !io_hit && hit |=> rsp_valid); // R2
  AST_FAULT_CARRIES_NO_DATA: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid && rsp_fault |-> rsp_rdata == '0); // R3
  AST_STORE_NEVER_TRAPS: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_RESP && pw_q |=> rsp_valid && !rsp_fault); // R4
  AST_EVICT_ONLY_CLEAN_FLAG: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_EVICT |-> t_valid && t_dirty && !t_fault); // R5
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    st_q == ST_IDLE |-> !bus_req); // R7
  AST_MISS_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    accept && (io_hit || !hit) |=> busy); // R7
endmodule

// File: tb/tb_fault_tag_dcache.sv
module tb_fault_tag_dcache;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        busy, rsp_valid, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_ack, bus_err;
  logic [31:0] bus_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_tag_dcache dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  int n_chk = 0, n_bad = 0, bus_cnt = 0, bad_wr = 0;
  bit done = 1'b0;
  logic [31:0] mem [2048];
  logic [31:0] ref_mem [2048];
  logic [31:0] io_mem [16];
  logic [31:0] io_ref [16];

  function automatic logic [31:0] seed_word(int i);
    return (i * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  function automatic bit is_io(logic [31:0] a);
    return (a & 32'hFFFF_0000) == 32'h1000_0000;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory responder: error region is addr[12]=1 (cached) or addr[6]=1 (uncached)
  initial begin
    int dly = 0;
    bus_ack = 0; bus_err = 0; bus_rdata = '0;
    for (int i = 0; i < 2048; i++) mem[i] = seed_word(i);
    for (int i = 0; i < 16; i++) io_mem[i] = 32'hA000_0000 | i;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 0; bus_err = 0; bus_rdata = '0;
      end else if (bus_req) begin
        if (dly > 0) dly--;
        else begin
          dly = $urandom % 3;
          bus_ack = 1; bus_cnt++;
          if (is_io(bus_addr)) begin
            bus_err = bus_addr[6];
            bus_rdata = bus_err ? 32'hDEAD_BEEF : io_mem[bus_addr[5:2]];
            if (bus_we && !bus_err) io_mem[bus_addr[5:2]] = merge(io_mem[bus_addr[5:2]], bus_wdata, bus_be);
          end else begin
            bus_err = bus_addr[12];
            bus_rdata = bus_err ? 32'hDEAD_BEEF : mem[bus_addr[11:2]];
            if (bus_we) begin
              if (bus_err) bad_wr++;
              else mem[bus_addr[11:2]] = merge(mem[bus_addr[11:2]], bus_wdata, bus_be);
            end
          end
        end
      end
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be, output logic [31:0] rd, output bit flt,
                        output int nb, output int cyc, output bit busy1);
    int nb0;
    @(negedge clk);
    while (busy) @(negedge clk);
    nb0 = bus_cnt;
    req_valid = 1; req_write = we; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    busy1 = busy;
    cyc = 1;
    while (!rsp_valid && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    rd = rsp_rdata; flt = rsp_fault; nb = bus_cnt - nb0;
  endtask

  // access + check against the reference model; exp_nb < 0 means beats not checked
  task automatic run(input bit we, input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] be, input int exp_nb, input string rq);
    logic [31:0] rd; bit flt; int nb, cyc; bit b1;
    access(we, a, d, be, rd, flt, nb, cyc, b1);
    if (is_io(a)) begin
      chk(flt == a[6], {rq, " R6 fault"}, 32'(flt), 32'(a[6]));
      chk(nb == 1, {rq, " R6 one beat"}, nb, 1);
      if (!we) chk(rd == (a[6] ? 32'h0 : io_ref[a[5:2]]), {rq, " R6 data"}, rd, io_ref[a[5:2]]);
      else if (!a[6]) io_ref[a[5:2]] = merge(io_ref[a[5:2]], d, be);
    end else if (a[12]) begin
      if (we) chk(flt == 0, {rq, " R4 store silent"}, 32'(flt), 0);
      else chk(flt == 1 && rd == 0, {rq, " R3 load fault"}, {rd[30:0], flt}, 32'h1);
    end else begin
      chk(flt == 0, {rq, " R1 no fault"}, 32'(flt), 0);
      if (!we) chk(rd == ref_mem[a[11:2]], {rq, " R1 data"}, rd, ref_mem[a[11:2]]);
      else ref_mem[a[11:2]] = merge(ref_mem[a[11:2]], d, be);
    end
    if (exp_nb >= 0) chk(nb == exp_nb, {rq, " bus beats"}, nb, exp_nb);
  endtask

  initial begin
    logic [31:0] rd; bit flt, b1; int nb, cyc;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2048; i++) ref_mem[i] = seed_word(i);
    for (int i = 0; i < 16; i++) io_ref[i] = 32'hA000_0000 | i;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !bus_req, "R9 reset outputs", {rsp_valid, bus_req}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!busy, "R9 idle after reset", 32'(busy), 0);

    run(0, 32'h100, 0, 0, 4, "R9 cold miss");
    access(0, 32'h100, 0, 0, rd, flt, nb, cyc, b1);
    chk(nb == 0 && cyc == 1 && !b1, "R2 load hit timing", {nb[15:0], cyc[15:0]}, 32'h0000_0001);
    run(1, 32'h100, 32'h1122_3344, 4'b0101, 0, "R2 store hit");
    run(0, 32'h100, 0, 0, 0, "R1 byte merge");
    run(0, 32'h200, 0, 0, 8, "R5 dirty victim");
    run(0, 32'h100, 0, 0, 4, "R1 after writeback");
    run(0, 32'h1100, 0, 0, 4, "R3 error refill");
    run(1, 32'h1104, 32'hCAFE_F00D, 4'hF, 0, "R4 store to faulted");
    run(0, 32'h1104, 0, 0, 0, "R3 faulted hit");
    run(0, 32'h100, 0, 0, 4, "R5 faulted victim dropped");
    run(0, 32'h104, 0, 0, 0, "R8 fault cleared");
    run(0, 32'h1000_0008, 0, 0, 1, "R6 io load");
    run(1, 32'h1000_0008, 32'h5566_7788, 4'b0011, 1, "R6 io store");
    run(0, 32'h1000_0008, 0, 0, 1, "R6 io readback");
    run(0, 32'h1000_0044, 0, 0, 1, "R6 io error");
    access(0, 32'h340, 0, 0, rd, flt, nb, cyc, b1);
    chk(b1, "R7 busy during miss", 32'(b1), 1);
    chk(rd == ref_mem[32'h340 >> 2], "R7 miss data", rd, ref_mem[32'h340 >> 2]);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a; bit we; logic [3:0] be;
      if ($urandom % 10 == 0) a = 32'h1000_0000 | (($urandom % 32) << 2);
      else begin
        a = ($urandom % 1024) << 2;
        if ($urandom % 8 == 0) a[12] = 1'b1;
      end
      we = $urandom % 2;
      be = 4'($urandom);
      run(we, a, $urandom, be, -1, "rand");
    end
    chk(bad_wr == 0, "R4 R5 no write reached error region", bad_wr, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule